// File: doc/BRIEF.md
# Stereo One-Bit Stream Decimating FIR

The block turns two one-bit oversampled streams (left and right) into one signed word per channel at one sixty-fourth of the bit rate. Each accepted bit enters a per-channel tap history. Once every `DECIM` accepted bits, the block convolves both histories with a fixed symmetric coefficient set, scales and rounds the sums, and presents them as a left/right pair marked by a single-cycle strobe.

A one-bit input can only be +1 or −1, so each tap adds or subtracts its coefficient and no multiplier is needed. The coefficients are symmetric, so the taps are folded in mirror pairs: two equal bits add or subtract twice the shared coefficient, and two unequal bits cancel. The symmetry gives linear phase, with a group delay of `(TAPS-1)/2` input bits. For `TAPS=4095` and `DECIM=64` that is 32 output periods. The system clock may run faster than the bit rate, and `in_valid` marks the cycles that carry a bit.

Top module: `bitstream_decimator`

## Requirements
- R1: One output pair is produced for every `DECIM` (default 64) accepted input bits. `out_valid` is high in the second clock cycle after the edge that accepts the `DECIM`-th bit of a group, counting from reset.
- R2: `out_valid` is high for exactly one cycle per group and is low at every other time.
- R3: Coefficient k (k=0 is the newest bit) equals min(k+1, TAPS−k), with TAPS odd. The pre-scaling sum is Σ c(k)·x(k) over all TAPS history positions, including the newest bit of the group.
- R4: An input bit of 1 weights its coefficient by +1, and a bit of 0 weights it by −1.
- R5: Reset loads each history with an alternating pattern: position k holds 1 when k is even and 0 when k is odd.
- R6: Let S=((TAPS+1)/2)², A=clog2(S)+1 and D=A−OW. If D>0, the sum is divided by 2^D and rounded to nearest, with exact halves rounded upward. If D≤0, the sum is multiplied by 2^(−D).
- R7: The scaled word saturates to the signed OW-bit range (an all-ones group clips to 2^(OW−1)−1).
- R8: When `short_mode` is high at the edge that computes a word, that word is rounded (halves upward) to SHORT_W bits, saturated to the SHORT_W-bit range, and placed in the upper SHORT_W bits with zeros below.
- R9: `out_l` and `out_r` change only on the cycle in which `out_valid` is high, and otherwise hold their last value.
- R10: Synchronous reset clears `out_valid`, `out_l`, `out_r` and the group bit counter.
- R11: `in_l` and `in_r` are ignored in cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a cycle carrying one bit per channel |
| in_l | input | 1 | Left one-bit stream |
| in_r | input | 1 | Right one-bit stream |
| short_mode | input | 1 | Selects the reduced SHORT_W-bit output word |
| out_valid | output | 1 | One-cycle strobe for a new output pair |
| out_l | output | OW | Left word, two's complement |
| out_r | output | OW | Right word, two's complement |

## Verification
The hardest behaviour to observe is the reset pattern in the history. It only affects output when the tap span is longer than one decimation group, and only in the first output after reset, including a reset that arrives partway through a group. The bench therefore uses a 127-tap filter with 64-bit groups and issues resets both at start-up and mid-group. It also sweeps the pulse density of the left and right streams in opposite directions over every value from 0 to 64 per group. These sweeps drive the scaled sum through both saturation limits and through the half-way rounding cases in both word widths.

// File: rtl/bitstream_decimator.sv
module bitstream_decimator #(
  parameter int TAPS    = 255,
  parameter int DECIM   = 64,
  parameter int OW      = 18,
  parameter int SHORT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_l,
  input  logic                 in_r,
  input  logic                 short_mode,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_l,
  output logic signed [OW-1:0] out_r
);
  localparam int MID  = (TAPS - 1) / 2;
  localparam int SUMC = (MID + 1) * (MID + 1);
  localparam int AW   = $clog2(SUMC) + 1;
  localparam int ACW  = AW + 1;
  localparam int RSH  = (AW > OW) ? AW - OW : 0;
  localparam int LSH  = (OW > AW) ? OW - AW : 0;
  localparam int SSH  = OW - SHORT_W;
  localparam int WW   = ACW + LSH + 2;
  localparam int PW   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PW-1:0] LAST = PW'(DECIM - 1);
  localparam logic signed [WW-1:0] RND  = WW'((1 <<< RSH) >>> 1);
  localparam logic signed [WW-1:0] SRND = WW'((1 <<< SSH) >>> 1);

  function automatic logic [TAPS-1:0] alt_init();
    logic [TAPS-1:0] p;
    for (int k = 0; k < TAPS; k++) p[k] = (k % 2 == 0);
    return p;
  endfunction

  function automatic logic signed [ACW-1:0] coefv(input int k);
    return ACW'((k <= MID) ? k + 1 : TAPS - k);
  endfunction

  function automatic logic signed [ACW-1:0] fir_sum(input logic [TAPS-1:0] h);
    logic signed [ACW-1:0] s;
    s = '0;
    for (int k = 0; k < MID; k++) begin
      if (h[k] && h[TAPS-1-k])        s = s + (coefv(k) <<< 1);
      else if (!h[k] && !h[TAPS-1-k]) s = s - (coefv(k) <<< 1);
    end
    s = h[MID] ? s + coefv(MID) : s - coefv(MID);
    return s;
  endfunction

  function automatic logic signed [WW-1:0] clip(input logic signed [WW-1:0] v, input int w);
    logic signed [WW-1:0] hi, lo;
    hi = (WW'(1) <<< (w - 1)) - WW'(1);
    lo = -hi - WW'(1);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic signed [OW-1:0] shape(input logic signed [ACW-1:0] a, input logic shrt);
    logic signed [WW-1:0] v;
    v = WW'(a) <<< LSH;
    v = (v + RND) >>> RSH;
    v = clip(v, OW);
    if (shrt) begin
      v = (v + SRND) >>> SSH;
      v = clip(v, SHORT_W);
      v = v <<< SSH;
    end
    return v[OW-1:0];
  endfunction

  logic [TAPS-1:0] hist_l, hist_r;
  logic [PW-1:0]   phase;
  logic            fire;
  logic signed [ACW-1:0] acc_l, acc_r;

  assign acc_l = fir_sum(hist_l);
  assign acc_r = fir_sum(hist_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      fire      <= 1'b0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      hist_l    <= alt_init();
      hist_r    <= alt_init();
    end else begin
      fire      <= in_valid && (phase == LAST);
      out_valid <= fire;
      if (in_valid) begin
        phase  <= (phase == LAST) ? '0 : phase + 1'b1;
        hist_l <= {hist_l[TAPS-2:0], in_l};
        hist_r <= {hist_r[TAPS-2:0], in_r};
      end
      if (fire) begin
        out_l <= shape(acc_l, short_mode);
        out_r <= shape(acc_r, short_mode);
      end
    end
  end
endmodule

// File: rtl/bitstream_decimator_chk.sv
module bitstream_decimator_chk #(
  parameter int DECIM   = 64,
  parameter int OW      = 18,
  parameter int SHORT_W = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          short_mode,
  input logic          out_valid,
  input logic [OW-1:0] out_l,
  input logic [OW-1:0] out_r
);
  localparam int PW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [OW-1:0] LOWMASK = OW'((1 <<< (OW - SHORT_W)) - 1);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (in_valid) cnt <= (cnt == PW'(DECIM - 1)) ? '0 : cnt + 1'b1;
  end

  // R1
  pulse_timing_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid, 2) && $past(cnt, 2) == PW'(DECIM - 1)));
  // R1
  pulse_due_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid, 2) && $past(cnt, 2) == PW'(DECIM - 1) && !$past(rst, 1)) |-> out_valid);
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(out_l) || !$stable(out_r)) |-> out_valid);
  // R8
  short_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(short_mode)) |-> ((out_l & LOWMASK) == '0 && (out_r & LOWMASK) == '0));
  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_l == '0 && out_r == '0));
endmodule

bind bitstream_decimator bitstream_decimator_chk #(.DECIM(DECIM), .OW(OW), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .short_mode(short_mode),
  .out_valid(out_valid), .out_l(out_l), .out_r(out_r));

// File: tb/bitstream_decimator_bench.sv
module bitstream_decimator_bench;
  localparam int TAPS = 127, DECIM = 64, OW = 11, SHORT_W = 9;
  localparam int MID  = (TAPS - 1) / 2;
  localparam int S    = (MID + 1) * (MID + 1);
  localparam int A    = $clog2(S) + 1;
  localparam int RSH  = (A > OW) ? A - OW : 0;
  localparam int LSH  = (OW > A) ? OW - A : 0;
  localparam int SSH  = OW - SHORT_W;

  logic clk = 0, rst = 1, in_valid = 0, in_l = 0, in_r = 0, short_mode = 0;
  logic out_valid;
  logic signed [OW-1:0] out_l, out_r;

  bitstream_decimator #(.TAPS(TAPS), .DECIM(DECIM), .OW(OW), .SHORT_W(SHORT_W)) u_bitstream_decimator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .short_mode(short_mode), .out_valid(out_valid), .out_l(out_l), .out_r(out_r));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, nb = 0;
  int last_l = 0, last_r = 0;
  bit hl[TAPS], hr[TAPS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int w);
    int hi = (1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < -hi - 1) return -hi - 1;
    return v;
  endfunction

  function automatic int model(input bit right, input bit shrt);
    int acc = 0, v;
    for (int k = 0; k < TAPS; k++) begin
      int c = (k + 1 < TAPS - k) ? k + 1 : TAPS - k;
      acc += ((right ? hr[k] : hl[k]) ? c : -c);
    end
    v = ((acc * (1 <<< LSH)) + ((1 <<< RSH) >>> 1)) >>> RSH;
    v = clampi(v, OW);
    if (shrt) begin
      v = (v + ((1 <<< SSH) >>> 1)) >>> SSH;
      v = clampi(v, SHORT_W) * (1 <<< SSH);
    end
    return v;
  endfunction

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int k = 0; k < TAPS; k++) begin hl[k] = (k % 2 == 0); hr[k] = (k % 2 == 0); end
    nb = 0; last_l = 0; last_r = 0;
    chk(out_valid == 0, "R10 valid", int'(out_valid), 0);
    chk(out_l == 0 && out_r == 0, "R10 data", int'(out_l), 0);
  endtask

  task automatic send_bit(input bit l, input bit r);
    in_valid = 1; in_l = l; in_r = r;
    @(negedge clk);
    in_valid = 0; in_l = 1'($urandom); in_r = 1'($urandom);
    for (int k = TAPS - 1; k > 0; k--) begin hl[k] = hl[k-1]; hr[k] = hr[k-1]; end
    hl[0] = l; hr[0] = r; nb++;
    chk(out_valid == 0, "R2 early", int'(out_valid), 0);
    if (nb % DECIM == 0) begin
      last_l = model(0, short_mode);
      last_r = model(1, short_mode);
      @(negedge clk);
      chk(out_valid == 1, "R1 strobe", int'(out_valid), 1);
      // R3 R4 R6 R7 R8 R11: value checks
      chk(int'(out_l) == last_l, "R3 left", int'(out_l), last_l);
      chk(int'(out_r) == last_r, "R3 right", int'(out_r), last_r);
    end else begin
      @(negedge clk);
      chk(out_valid == 0 && int'(out_l) == last_l && int'(out_r) == last_r,
          "R9 hold", int'(out_l), last_l);
    end
    @(negedge clk);
    chk(out_valid == 0, "R2 width", int'(out_valid), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R5: first group still sees the alternating reset history
    for (int i = 0; i < DECIM; i++) send_bit(1, 0);
    // R7: all ones and all zeros
    for (int g = 0; g < 3; g++) for (int i = 0; i < DECIM; i++) send_bit(1, 0);
    chk(last_l == (1 <<< (OW - 1)) - 1, "R7 max", last_l, (1 <<< (OW - 1)) - 1);
    chk(last_r == -(1 <<< (OW - 1)), "R7 min", last_r, -(1 <<< (OW - 1)));
    short_mode = 1;
    for (int g = 0; g < 2; g++) for (int i = 0; i < DECIM; i++) send_bit(1, 0);
    chk(last_l == ((1 <<< (SHORT_W - 1)) - 1) * (1 <<< SSH), "R8 max", last_l,
        ((1 <<< (SHORT_W - 1)) - 1) * (1 <<< SSH));
    // R6 R8: density sweep, left rising and right falling
    for (int d = 0; d <= DECIM; d++) begin
      short_mode = d[0];
      for (int i = 0; i < DECIM; i++)
        send_bit(((i * d) % DECIM) < d, ((i * (DECIM - d)) % DECIM) < (DECIM - d));
    end
    // R4: random streams
    for (int g = 0; g < 30; g++) begin
      short_mode = g[1];
      for (int i = 0; i < DECIM; i++) send_bit(1'($urandom), 1'($urandom));
    end
    // R5 R10: reset in the middle of a group
    for (int i = 0; i < 30; i++) send_bit(1'($urandom), 1'($urandom));
    do_reset();
    short_mode = 0;
    for (int g = 0; g < 2; g++) for (int i = 0; i < DECIM; i++) send_bit(i[0], !i[1]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule